// File: doc/BRIEF.md
# Command Queue Ring Controller

This block owns the software-visible registers of a command queue that lives in system memory as a ring of 32-byte slots: a control register, a queue-base register, a producer (write) pointer, a consumer (read) pointer and two table-base registers. The table-base registers exist only to gate enabling. Software programs these registers through a small MMIO port that carries 32-bit or 64-bit accesses with a byte offset. Software places commands in memory and then moves the write pointer. Once the block is enabled, it walks the ring from the read pointer up to the write pointer. For each slot it issues one 32-byte read on a simple memory-read port. It then passes each successfully fetched command to a downstream consumer over a valid/ready handshake.

Both pointers are byte offsets into the ring and are always multiples of 32. The ring length is set by a page-count field in the queue-base register. Enabling is refused until the queue base and both table bases are marked valid. The control register reports a quiescent flag whenever the two pointers are equal. A slot whose fetch returns an error is dropped, and the walk moves on past it.

Register offsets (bits 2..0 of the byte offset are zero for 64-bit access): 0x00 control, 0x08 queue base, 0x10 write pointer, 0x18 read pointer, 0x20 table base A, 0x28 table base B. Any other offset reads zero and ignores writes.

Top module: `cmdq_ring_ctrl`

## Requirements
- R1: After reset, enable is 0, both pointers are 0 and the queue base and both table bases are 0, so the control register reads 0x8000_0000.
- R2: With reg_wide_i=0, an access reaches one 32-bit half of a 64-bit register, picked by offset bit 2 (1 = bits 63:32), and merges into the stored value. The other half keeps its contents; 32-bit reads return the selected half in bits 31:0.
- R3: A control write that sets bit 0 while disabled is ignored unless bit 63 is set in the queue base and in both table bases; clearing bit 0 is always accepted.
- R4: The control register reads enable in bit 0 and reads 1 in bit 31 exactly when the read pointer equals the write pointer; all other bits read 0.
- R5: A queue-base write takes effect only while disabled and with no slot in flight. It stores the value with bits 15:12 forced to 0 and sets both pointers to 0. Otherwise the write is ignored.
- R6: Ring size in bytes is (queue base bits 7:0 + 1) * 4096. A write-pointer write keeps only offset bits 19:5. It is discarded entirely if that offset is not below the ring size.
- R7: Fetches are launched only while enabled and while the pointers differ. Only one fetch is in flight at a time. The fetch address is queue base bits 51:16 (low 16 bits zero) plus the read pointer. A request is held with a stable address until fetch_ready_i.
- R8: A fetched command is held stable on cmd_data_o with cmd_valid_o until cmd_ready_i. On acceptance the read pointer advances by 32 and wraps to 0 when it reaches the ring size, and commands are delivered in ring order.
- R9: A fetch response with fetch_rerr_i set produces no command, and the read pointer still advances past that slot.
- R10: Table-base writes are ignored while enabled; writes to the read-pointer offset are always ignored.
- R11: Clearing enable lets a slot already in flight finish but launches no new fetch. Setting enable again resumes the walk from the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr_i | input | REG_AW (6) | Byte offset; bits 1:0 must be 0 |
| reg_wdata_i | input | 64 | Write data (32-bit writes use bits 31:0) |
| reg_rdata_o | output | 64 | Read data, valid in the cycle of reg_req_i |
| fetch_req_o | output | 1 | Slot fetch request |
| fetch_ready_i | input | 1 | Memory accepts the request |
| fetch_addr_o | output | PA_W (52) | Byte address of the slot |
| fetch_rvalid_i | input | 1 | Fetch response valid |
| fetch_rerr_i | input | 1 | Fetch response is an error |
| fetch_rdata_i | input | CMD_W (256) | Fetched command |
| cmd_valid_o | output | 1 | Command available to the consumer |
| cmd_ready_i | input | 1 | Consumer takes the command |
| cmd_data_o | output | CMD_W (256) | Command contents |

## Verification
The write pointer can be rewritten in the same cycle that the consumer accepts a command and the read pointer moves. The bench sets this up by extending the write pointer a few cycles into a long wrapping walk, while a consumer with irregular ready stalls the walk. A scoreboard that was loaded at each write-pointer update must then be drained exactly in ring order, with the final read pointer on the new target. A second overlap is a control write that clears enable while a slot is in flight. The bench judges it by the fetch count freezing, the read pointer stopping short of the write pointer with the quiescent flag clear, and the rest of the walk completing after enable is set again.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int unsigned CMD_BYTES  = 32;
  localparam int unsigned CMD_LSB    = $clog2(CMD_BYTES);
  localparam int unsigned ALIGN_LSB  = 16;
  localparam int unsigned VALID_BIT  = 63;
  localparam int unsigned QUIET_BIT  = 31;

  localparam logic [2:0] IDX_CTRL  = 3'd0;
  localparam logic [2:0] IDX_QBASE = 3'd1;
  localparam logic [2:0] IDX_WPTR  = 3'd2;
  localparam logic [2:0] IDX_RPTR  = 3'd3;
  localparam logic [2:0] IDX_TBLA  = 3'd4;
  localparam logic [2:0] IDX_TBLB  = 3'd5;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_REQ,
    FS_WAIT,
    FS_HAND
  } fetch_state_e;

  // Merge a 32- or 64-bit write into a stored 64-bit value.
  function automatic logic [63:0] merge64(input logic [63:0] old_v,
                                          input logic [63:0] wdata,
                                          input logic wide,
                                          input logic hi);
    if (wide)    return wdata;
    else if (hi) return {wdata[31:0], old_v[31:0]};
    else         return {old_v[63:32], wdata[31:0]};
  endfunction

  function automatic logic [63:0] lane64(input logic [63:0] v,
                                         input logic wide,
                                         input logic hi);
    if (wide)    return v;
    else if (hi) return {32'h0, v[63:32]};
    else         return {32'h0, v[31:0]};
  endfunction
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int unsigned SIZE_W     = 8,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned PTR_W     = SIZE_W + PAGE_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wide_i,
  input  logic             hi_i,
  input  logic [2:0]       idx_i,
  input  logic [63:0]      wdata_i,
  input  logic             idle_i,
  output logic             en_o,
  output logic [63:0]      qbase_o,
  output logic [63:0]      tbla_o,
  output logic [63:0]      tblb_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W:0]   ring_bytes_o,
  output logic             ptr_clr_o
);
  localparam logic [63:0] QB_CLR_MASK =
    ~(((64'd1 << (ALIGN_LSB - PAGE_SHIFT)) - 64'd1) << PAGE_SHIFT);

  logic             en_q;
  logic [63:0]      qbase_q, tbla_q, tblb_q;
  logic [PTR_W-1:0] wptr_q;
  logic             low_hit;
  logic             all_valid;
  logic             ctrl_we, qbase_we, wptr_we, tbla_we, tblb_we;
  logic [PTR_W-1:0] wptr_raw, wptr_cand;
  logic             wptr_fits;

  assign low_hit   = wide_i || !hi_i;
  assign all_valid = qbase_q[VALID_BIT] && tbla_q[VALID_BIT] && tblb_q[VALID_BIT];

  assign ring_bytes_o =
    ({{(PTR_W + 1 - SIZE_W){1'b0}}, qbase_q[SIZE_W-1:0]} + (PTR_W+1)'(1)) << PAGE_SHIFT;

  // Offset bits live in the low half; a high-half write leaves them as they were.
  assign wptr_raw  = low_hit ? wdata_i[PTR_W-1:0] : wptr_q;
  assign wptr_cand = {wptr_raw[PTR_W-1:CMD_LSB], {CMD_LSB{1'b0}}};
  assign wptr_fits = {1'b0, wptr_cand} < ring_bytes_o;

  assign ctrl_we  = wr_i && (idx_i == IDX_CTRL) && low_hit &&
                    (en_q || !wdata_i[0] || all_valid);
  assign qbase_we = wr_i && (idx_i == IDX_QBASE) && !en_q && idle_i;
  assign wptr_we  = wr_i && (idx_i == IDX_WPTR) && wptr_fits;
  assign tbla_we  = wr_i && (idx_i == IDX_TBLA) && !en_q;
  assign tblb_we  = wr_i && (idx_i == IDX_TBLB) && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      qbase_q <= '0;
      tbla_q  <= '0;
      tblb_q  <= '0;
      wptr_q  <= '0;
    end else begin
      if (ctrl_we) en_q <= wdata_i[0];
      if (qbase_we) begin
        qbase_q <= merge64(qbase_q, wdata_i, wide_i, hi_i) & QB_CLR_MASK;
        wptr_q  <= '0;
      end else if (wptr_we) begin
        wptr_q  <= wptr_cand;
      end
      if (tbla_we) tbla_q <= merge64(tbla_q, wdata_i, wide_i, hi_i);
      if (tblb_we) tblb_q <= merge64(tblb_q, wdata_i, wide_i, hi_i);
    end
  end

  assign en_o      = en_q;
  assign qbase_o   = qbase_q;
  assign tbla_o    = tbla_q;
  assign tblb_o    = tblb_q;
  assign wptr_o    = wptr_q;
  assign ptr_clr_o = qbase_we;
endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
  import cmdq_pkg::*;
#(
  parameter int unsigned PTR_W = 20,
  parameter int unsigned PA_W  = 52,
  parameter int unsigned CMD_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [PTR_W-1:0] wptr_i,
  input  logic [PTR_W:0]   ring_bytes_i,
  input  logic [PA_W-1:0]  base_i,
  output logic [PTR_W-1:0] rptr_o,
  output logic             idle_o,
  output logic             fetch_req_o,
  input  logic             fetch_ready_i,
  output logic [PA_W-1:0]  fetch_addr_o,
  input  logic             fetch_rvalid_i,
  input  logic             fetch_rerr_i,
  input  logic [CMD_W-1:0] fetch_rdata_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [CMD_W-1:0] cmd_data_o
);
  fetch_state_e     state_q, state_d;
  logic [PTR_W-1:0] rptr_q;
  logic [PTR_W:0]   rptr_inc;
  logic [PTR_W-1:0] rptr_nxt;
  logic             advance;
  logic [CMD_W-1:0] cmd_q;

  assign rptr_inc = {1'b0, rptr_q} + (PTR_W+1)'(CMD_BYTES);
  assign rptr_nxt = (rptr_inc == ring_bytes_i) ? '0 : rptr_inc[PTR_W-1:0];

  always_comb begin
    state_d = state_q;
    advance = 1'b0;
    unique case (state_q)
      FS_IDLE: if (en_i && (rptr_q != wptr_i)) state_d = FS_REQ;
      FS_REQ:  if (fetch_ready_i) state_d = FS_WAIT;
      FS_WAIT: if (fetch_rvalid_i) begin
        if (fetch_rerr_i) begin
          advance = 1'b1;
          state_d = FS_IDLE;
        end else begin
          state_d = FS_HAND;
        end
      end
      FS_HAND: if (cmd_ready_i) begin
        advance = 1'b1;
        state_d = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      rptr_q  <= '0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      if (clr_i)        rptr_q <= '0;
      else if (advance) rptr_q <= rptr_nxt;
      if (state_q == FS_WAIT && fetch_rvalid_i && !fetch_rerr_i) cmd_q <= fetch_rdata_i;
    end
  end

  assign rptr_o       = rptr_q;
  assign idle_o       = (state_q == FS_IDLE);
  assign fetch_req_o  = (state_q == FS_REQ);
  assign fetch_addr_o = base_i + PA_W'(rptr_q);
  assign cmd_valid_o  = (state_q == FS_HAND);
  assign cmd_data_o   = cmd_q;
endmodule

// File: rtl/cmdq_ring_ctrl.sv
module cmdq_ring_ctrl
  import cmdq_pkg::*;
#(
  parameter int unsigned REG_AW     = 6,
  parameter int unsigned SIZE_W     = 8,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned PA_W       = 52,
  parameter int unsigned CMD_W      = CMD_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic              reg_wide_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              fetch_req_o,
  input  logic              fetch_ready_i,
  output logic [PA_W-1:0]   fetch_addr_o,
  input  logic              fetch_rvalid_i,
  input  logic              fetch_rerr_i,
  input  logic [CMD_W-1:0]  fetch_rdata_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [CMD_W-1:0]  cmd_data_o
);
  localparam int unsigned PTR_W = SIZE_W + PAGE_SHIFT;

  logic             sel, wr, hi;
  logic [2:0]       idx;
  logic             en_w, idle_w, clr_w, quiet_w;
  logic [63:0]      qbase_w, tbla_w, tblb_w;
  logic [PTR_W-1:0] wptr_w, rptr_w;
  logic [PTR_W:0]   ring_w;
  logic [PA_W-1:0]  base_w;
  logic [63:0]      rd_full;

  assign sel = reg_req_i && (reg_addr_i[1:0] == 2'b00) &&
               (reg_addr_i[REG_AW-1:3] < (REG_AW-3)'(6));
  assign wr  = sel && reg_we_i;
  assign hi  = reg_addr_i[2];
  assign idx = 3'(reg_addr_i[REG_AW-1:3]);

  assign base_w  = {qbase_w[PA_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  assign quiet_w = (rptr_w == wptr_w);

  cmdq_regs #(
    .SIZE_W    (SIZE_W),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .wide_i      (reg_wide_i),
    .hi_i        (hi),
    .idx_i       (idx),
    .wdata_i     (reg_wdata_i),
    .idle_i      (idle_w),
    .en_o        (en_w),
    .qbase_o     (qbase_w),
    .tbla_o      (tbla_w),
    .tblb_o      (tblb_w),
    .wptr_o      (wptr_w),
    .ring_bytes_o(ring_w),
    .ptr_clr_o   (clr_w)
  );

  cmdq_fetch #(
    .PTR_W(PTR_W),
    .PA_W (PA_W),
    .CMD_W(CMD_W)
  ) u_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_w),
    .clr_i         (clr_w),
    .wptr_i        (wptr_w),
    .ring_bytes_i  (ring_w),
    .base_i        (base_w),
    .rptr_o        (rptr_w),
    .idle_o        (idle_w),
    .fetch_req_o   (fetch_req_o),
    .fetch_ready_i (fetch_ready_i),
    .fetch_addr_o  (fetch_addr_o),
    .fetch_rvalid_i(fetch_rvalid_i),
    .fetch_rerr_i  (fetch_rerr_i),
    .fetch_rdata_i (fetch_rdata_i),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_ready_i   (cmd_ready_i),
    .cmd_data_o    (cmd_data_o)
  );

  always_comb begin
    rd_full = '0;
    unique case (idx)
      IDX_CTRL: begin
        rd_full[0]         = en_w;
        rd_full[QUIET_BIT] = quiet_w;
      end
      IDX_QBASE: rd_full = qbase_w;
      IDX_WPTR:  rd_full = 64'(wptr_w);
      IDX_RPTR:  rd_full = 64'(rptr_w);
      IDX_TBLA:  rd_full = tbla_w;
      IDX_TBLB:  rd_full = tblb_w;
      default:   rd_full = '0;
    endcase
  end

  assign reg_rdata_o = sel ? lane64(rd_full, reg_wide_i, hi) : '0;
endmodule

// File: rtl/cmdq_ring_ctrl_chk.sv
module cmdq_ring_ctrl_chk #(
  parameter int unsigned PTR_W = 20,
  parameter int unsigned PA_W  = 52,
  parameter int unsigned CMD_W = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en,
  input logic [63:0]      qbase,
  input logic [63:0]      tbla,
  input logic [63:0]      tblb,
  input logic [PTR_W-1:0] rptr,
  input logic [PTR_W-1:0] wptr,
  input logic [PTR_W:0]   ring,
  input logic             fetch_req,
  input logic             fetch_ready,
  input logic [PA_W-1:0]  fetch_addr,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [CMD_W-1:0] cmd_data
);
  assert_enable_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !$past(en)) |-> $past(qbase[63] && tbla[63] && tblb[63]));

  assert_qbase_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qbase[15:12] == 4'h0);

  assert_wptr_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wptr[4:0] == 5'd0) && ({1'b0, wptr} < ring));

  assert_fetch_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_req) |-> $past(en));

  assert_fetch_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req && !fetch_ready) |=> (fetch_req && $stable(fetch_addr)));

  assert_fetch_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req |-> (fetch_addr[4:0] == 5'd0));

  assert_cmd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  assert_rptr_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rptr[4:0] == 5'd0) && ({1'b0, rptr} < ring));
endmodule

bind cmdq_ring_ctrl cmdq_ring_ctrl_chk #(
  .PTR_W(SIZE_W + PAGE_SHIFT),
  .PA_W (PA_W),
  .CMD_W(CMD_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en         (en_w),
  .qbase      (qbase_w),
  .tbla       (tbla_w),
  .tblb       (tblb_w),
  .rptr       (rptr_w),
  .wptr       (wptr_w),
  .ring       (ring_w),
  .fetch_req  (fetch_req_o),
  .fetch_ready(fetch_ready_i),
  .fetch_addr (fetch_addr_o),
  .cmd_valid  (cmd_valid_o),
  .cmd_ready  (cmd_ready_i),
  .cmd_data   (cmd_data_o)
);

// File: tb/tb_cmdq_ring_ctrl.sv
`timescale 1ns/1ps
module tb_cmdq_ring_ctrl;
  localparam int CMD_W = 256;
  localparam logic [63:0] QB_WR  = 64'h8000_0000_1234_F001;
  localparam logic [63:0] QB_RD  = 64'h8000_0000_1234_0001;
  localparam logic [51:0] BASE   = 52'h1234_0000;
  localparam int          RING   = 8192;

  logic clk = 0, rst_n = 0;
  logic reg_req = 0, reg_we = 0, reg_wide = 0;
  logic [5:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic fetch_req, fetch_ready = 1, fetch_rvalid = 0, fetch_rerr = 0;
  logic [51:0] fetch_addr;
  logic [CMD_W-1:0] fetch_rdata = '0, cmd_data;
  logic cmd_valid, cmd_ready = 0;

  int tests = 0, fails = 0, fetch_cnt = 0;
  int m_wptr = 0;
  logic [51:0] err_addr = '1;
  logic [CMD_W-1:0] exp_q[$];
  logic [63:0] rd;
  bit run_cons = 1;

  always #2 clk = ~clk;

  cmdq_ring_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_wide_i(reg_wide),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .fetch_req_o(fetch_req), .fetch_ready_i(fetch_ready), .fetch_addr_o(fetch_addr),
    .fetch_rvalid_i(fetch_rvalid), .fetch_rerr_i(fetch_rerr), .fetch_rdata_i(fetch_rdata),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data)
  );

  function automatic logic [CMD_W-1:0] pat(input logic [51:0] a);
    return {4{a[31:0], ~a[31:0]}};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [63:0] d, input logic wide);
    @(posedge clk); #1;
    reg_req = 1; reg_we = 1; reg_wide = wide; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [5:0] a, input logic wide, output logic [63:0] d);
    @(posedge clk); #1;
    reg_req = 1; reg_we = 0; reg_wide = wide; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    @(posedge clk); #1;
    reg_req = 0;
  endtask

  // Driver: expected commands for slots from the model write pointer to the new one.
  task automatic push_wptr(input int nw);
    int p = m_wptr;
    while (p != nw) begin
      if ((BASE + 52'(p)) != err_addr) exp_q.push_back(pat(BASE + 52'(p)));
      p += 32;
      if (p == RING) p = 0;
    end
    m_wptr = nw;
    reg_wr(6'h10, 64'(nw), 1'b1);
  endtask

  task automatic drain(input string req);
    int n = 0;
    rd = '0;
    while (n < 20000 && !(rd[31] && exp_q.size() == 0)) begin
      reg_rd(6'h00, 1'b0, rd);
      n++;
    end
    check(req, 64'(exp_q.size()), 64'd0);
  endtask

  // Memory model: one request at a time, latency depends on address bit 5.
  initial begin
    forever begin
      @(negedge clk);
      if (fetch_req && fetch_ready) begin
        automatic logic [51:0] a = fetch_addr;
        fetch_cnt++;
        @(posedge clk); #1;
        fetch_ready = 0;
        repeat (a[5] ? 2 : 0) begin @(posedge clk); #1; end
        fetch_rvalid = 1;
        fetch_rerr   = (a == err_addr);
        fetch_rdata  = pat(a);
        @(posedge clk); #1;
        fetch_rvalid = 0; fetch_rerr = 0;
        fetch_ready  = 1;
      end
    end
  end

  // Consumer with irregular ready.
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c++;
      cmd_ready = run_cons && ((c % 5) != 1) && ((c % 7) != 3);
    end
  end

  // Monitor / scoreboard (R8).
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid && cmd_ready) begin
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R8: unexpected command 0x%0h expected none", cmd_data[63:0]);
        end else begin
          automatic logic [CMD_W-1:0] e = exp_q.pop_front();
          if (cmd_data !== e) begin
            fails++;
            $display("FAIL R8: command 0x%0h expected 0x%0h", cmd_data[63:0], e[63:0]);
          end
        end
      end
    end
  end

  initial begin
    #600000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int fc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    reg_rd(6'h00, 1'b0, rd); check("R1 ctrl", rd, 64'h8000_0000);
    reg_rd(6'h08, 1'b1, rd); check("R1 qbase", rd, 64'h0);
    reg_rd(6'h18, 1'b1, rd); check("R1 rptr", rd, 64'h0);

    // R5: sanitised queue base; R2 high-half read
    reg_wr(6'h08, QB_WR, 1'b1);
    reg_rd(6'h08, 1'b1, rd); check("R5 qbase bits 15:12", rd, QB_RD);
    reg_rd(6'h0C, 1'b0, rd); check("R2 qbase high half", rd, 64'h8000_0000);

    // R3: refused with table bases invalid
    reg_wr(6'h00, 64'h1, 1'b0);
    reg_rd(6'h00, 1'b0, rd); check("R3 enable refused", rd, 64'h8000_0000);

    // R2: half writes merge independently
    reg_wr(6'h20, 64'h1111, 1'b0);
    reg_wr(6'h24, 64'h8000_0000, 1'b0);
    reg_rd(6'h20, 1'b1, rd); check("R2 merged halves", rd, 64'h8000_0000_0000_1111);
    reg_wr(6'h28, 64'h8000_0000_0000_2222, 1'b1);

    // R6: write pointer masking and range
    reg_wr(6'h10, 64'h2000, 1'b1);
    reg_rd(6'h10, 1'b1, rd); check("R6 out-of-range discarded", rd, 64'h0);
    reg_wr(6'h10, 64'h1FFF, 1'b1);
    reg_rd(6'h10, 1'b1, rd); check("R6 bits 19:5 kept", rd, 64'h1FE0);
    reg_rd(6'h00, 1'b0, rd); check("R4 not quiescent", rd, 64'h0);

    // R5: queue-base write resets pointers
    reg_wr(6'h08, QB_WR, 1'b1);
    reg_rd(6'h10, 1'b1, rd); check("R5 wptr reset", rd, 64'h0);

    // R7: no fetch while disabled
    push_wptr(32'h60);
    repeat (20) @(posedge clk);
    check("R7 no fetch disabled", 64'(fetch_cnt), 64'd0);

    // R3/R7/R8: enable and walk
    reg_wr(6'h00, 64'h1, 1'b0);
    reg_rd(6'h00, 1'b0, rd); check("R4 enable readback", 64'(rd[0]), 64'd1);
    drain("R8 first walk");
    reg_rd(6'h18, 1'b1, rd); check("R8 rptr after walk", rd, 64'h60);
    reg_rd(6'h00, 1'b0, rd); check("R4 quiescent enabled", rd, 64'h8000_0001);

    // R5/R10: writes ignored while enabled
    reg_wr(6'h08, 64'h0, 1'b1);
    reg_rd(6'h08, 1'b1, rd); check("R5 qbase read-only", rd, QB_RD);
    reg_wr(6'h28, 64'h0, 1'b0);
    reg_rd(6'h28, 1'b1, rd); check("R10 table ignored", rd, 64'h8000_0000_0000_2222);
    reg_wr(6'h18, 64'h40, 1'b1);
    reg_rd(6'h18, 1'b1, rd); check("R10 rptr read-only", rd, 64'h60);

    // R9: error slot skipped
    err_addr = BASE + 52'h80;
    push_wptr(32'hC0);
    drain("R9 error slot");
    reg_rd(6'h18, 1'b1, rd); check("R9 rptr past error", rd, 64'hC0);
    err_addr = '1;

    // R8: wrap, with a write-pointer update in the middle of the walk
    push_wptr(32'h20);
    repeat (25) @(posedge clk);
    reg_rd(6'h00, 1'b0, rd); check("R4 busy not quiescent", 64'(rd[31]), 64'd0);
    push_wptr(32'h60);
    drain("R8 wrap walk");
    reg_rd(6'h18, 1'b1, rd); check("R8 rptr wrapped", rd, 64'h60);

    // R11: disable while walking
    push_wptr(32'h100);
    reg_wr(6'h00, 64'h0, 1'b0);
    repeat (15) @(posedge clk);
    fc = fetch_cnt;
    repeat (30) @(posedge clk);
    check("R11 fetches stopped", 64'(fetch_cnt), 64'(fc));
    reg_rd(6'h00, 1'b0, rd); check("R11 disabled pending", rd, 64'h0);
    reg_rd(6'h18, 1'b1, rd);
    check("R11 rptr stopped short", 64'(rd < 64'h100), 64'd1);
    reg_wr(6'h00, 64'h1, 1'b0);
    drain("R11 resumed walk");
    reg_rd(6'h18, 1'b1, rd); check("R11 rptr final", rd, 64'h100);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule